// File: doc/BRIEF.md
# Debug Command Protocol Responder

This block turns a stream of command bytes from a host into operations on a target processor's debug port, then answers with short coded reply bytes. Bytes arrive and leave over valid/ready byte interfaces that an external serial framer (8-bit characters at 19200 baud) feeds and drains. Each command begins with one opcode byte. Depending on the opcode, zero, one or four argument bytes follow.

Commands cover these actions: reading a debug register, writing one or four bytes, reading target status, entering and leaving debug mode, resetting the target and/or the responder's controller, a liveness ping, and a code-level query. Debug-port work goes through a request/acknowledge handshake. A programmable timeout turns a silent target into a failure or dead-target reply. Opcodes outside the command set are discarded. Bytes that arrive while a command is still running or its reply is still draining are also discarded.

Top module: `dbg_cmd_responder`

## Requirements
- R1: After reset, `tx_valid`, `dp_req`, `rst_ctrl_o` and `rst_tgt_o` are low and `rx_ready` is high.
- R2: Opcode 0xA0 followed by a select byte issues a debug-port request with `dp_op`=0 and `dp_wdata`={24'h0, select}. On acknowledge the reply is 0xD7 followed by `dp_rdata[23:16]`, `dp_rdata[15:8]` and `dp_rdata[7:0]`, in that order.
- R3: Opcode 0xA1 with one byte issues `dp_op`=1 with `dp_wdata`={24'h0, byte}. Opcode 0xA2 with four bytes issues `dp_op`=2 with `dp_wdata` built from the bytes, first byte most significant. On acknowledge either command replies 0xD1; on timeout it replies 0xD2.
- R4: Opcode 0xA5 issues `dp_op`=3 and replies 0xD5 on acknowledge or 0xD3 on timeout. Opcode 0xA6 issues `dp_op`=4 and replies 0xD4 whether or not the target acknowledges.
- R5: Opcode 0xA7 issues `dp_op`=5 and replies 0xD7 then `dp_rdata[7:0]` on acknowledge. A timeout on 0xA7 or on 0xA0 replies the single byte 0xD2.
- R6: Opcodes 0xA3, 0xA4 and 0xA9 send no reply bytes and issue no debug-port request. 0xA3 pulses both `rst_ctrl_o` and `rst_tgt_o` for one cycle, 0xA4 pulses only `rst_tgt_o`, and 0xA9 pulses only `rst_ctrl_o`.
- R7: Opcode 0xAC replies 0xD6. Opcode 0xAD replies the single byte given by parameter CODE_LEVEL (default 0x01). Neither issues a debug-port request.
- R8: Opcodes 0xA8, 0xAA, 0xAB and any byte outside the command set produce no reply, no request and no reset pulse. The next opcode byte is decoded normally.
- R9: A byte received while a command is executing or while reply bytes are still pending is discarded and has no effect.
- R10: A debug-port request stays high for at most max(`to_limit`,1) cycles. If `dp_ack` is not seen within that window, the command takes its timeout reply.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Responder takes bytes (always high; unwanted bytes are dropped) |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Sink takes the reply byte |
| to_limit | input | TO_W | Debug-port acknowledge window in cycles (0 acts as 1) |
| dp_req | output | 1 | Debug-port request |
| dp_op | output | 3 | Debug-port operation code |
| dp_wdata | output | 32 | Debug-port write data or register select |
| dp_rdata | input | 24 | Debug-port read data, valid with acknowledge |
| dp_ack | input | 1 | Debug-port acknowledge |
| rst_ctrl_o | output | 1 | One-cycle controller reset pulse |
| rst_tgt_o | output | 1 | One-cycle target reset pulse |

## Verification
Each opcode is driven against a responsive target and against a silent one, so that success codes are separated from failure and dead-target codes. The acknowledge delay is swept around the timeout window, including a limit of zero, to locate the exact cycle where success turns into timeout. Random opcode streams that mix valid, unused and foreign bytes with random argument values and random sink back-pressure show whether argument counting, byte order and reply ordering survive interleaving. Bytes injected during execution and during a stalled reply show whether the discard policy holds.

// File: rtl/dbgr_pkg.sv
package dbgr_pkg;

   localparam int ARG_BYTES = 4;
   localparam int RPL_BYTES = 4;
   localparam int RD_W      = 24;
   localparam int WD_W      = 32;

   // host opcodes
   localparam logic [7:0] OPC_RDREG  = 8'hA0;
   localparam logic [7:0] OPC_WR1    = 8'hA1;
   localparam logic [7:0] OPC_WR4    = 8'hA2;
   localparam logic [7:0] OPC_RSTALL = 8'hA3;
   localparam logic [7:0] OPC_RSTTGT = 8'hA4;
   localparam logic [7:0] OPC_HALT   = 8'hA5;
   localparam logic [7:0] OPC_FREE   = 8'hA6;
   localparam logic [7:0] OPC_STAT   = 8'hA7;
   localparam logic [7:0] OPC_RSTCTL = 8'hA9;
   localparam logic [7:0] OPC_PING   = 8'hAC;
   localparam logic [7:0] OPC_LEVEL  = 8'hAD;

   // reply codes
   localparam logic [7:0] RPL_WR_OK  = 8'hD1;
   localparam logic [7:0] RPL_FAIL   = 8'hD2;
   localparam logic [7:0] RPL_DEAD   = 8'hD3;
   localparam logic [7:0] RPL_FREED  = 8'hD4;
   localparam logic [7:0] RPL_HALTED = 8'hD5;
   localparam logic [7:0] RPL_ALIVE  = 8'hD6;
   localparam logic [7:0] RPL_DATA   = 8'hD7;

   typedef enum logic [2:0] {
      DP_RDREG = 3'd0,
      DP_WR1   = 3'd1,
      DP_WR4   = 3'd2,
      DP_HALT  = 3'd3,
      DP_FREE  = 3'd4,
      DP_STAT  = 3'd5
   } dp_op_e;

   function automatic logic [2:0] arg_count(input logic [7:0] opc);
      case (opc)
         OPC_RDREG, OPC_WR1: return 3'd1;
         OPC_WR4:            return 3'd4;
         default:            return 3'd0;
      endcase
   endfunction

   function automatic logic is_known(input logic [7:0] opc);
      case (opc)
         OPC_RDREG, OPC_WR1, OPC_WR4, OPC_RSTALL, OPC_RSTTGT, OPC_HALT,
         OPC_FREE, OPC_STAT, OPC_RSTCTL, OPC_PING, OPC_LEVEL: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dbgr_cmd_parse.sv
module dbgr_cmd_parse
   import dbgr_pkg::*;
#(
   parameter int ARG_MAX = ARG_BYTES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rx_valid,
   input  logic [7:0]             rx_data,
   input  logic                   busy,
   output logic                   cmd_valid,
   output logic [7:0]             cmd_opc,
   output logic [8*ARG_MAX-1:0]   cmd_args
);

   localparam int CNT_W = $clog2(ARG_MAX + 1);

   generate
      if (ARG_MAX < 4) begin : g_bad_args
         $error("dbgr_cmd_parse: ARG_MAX must hold the longest argument list");
      end
   endgenerate

   logic             collecting;
   logic [CNT_W-1:0] remain;
   logic             take;

   assign take = rx_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         collecting <= 1'b0;
         remain     <= '0;
         cmd_valid  <= 1'b0;
         cmd_opc    <= '0;
         cmd_args   <= '0;
      end else begin
         cmd_valid <= 1'b0;
         if (take) begin
            if (!collecting) begin
               if (is_known(rx_data)) begin
                  cmd_opc  <= rx_data;
                  cmd_args <= '0;
                  if (arg_count(rx_data) == 3'd0) begin
                     cmd_valid <= 1'b1;
                  end else begin
                     collecting <= 1'b1;
                     remain     <= CNT_W'(arg_count(rx_data));
                  end
               end
            end else begin
               cmd_args <= {cmd_args[8*ARG_MAX-9:0], rx_data};
               remain   <= remain - 1'b1;
               if (remain == CNT_W'(1)) begin
                  collecting <= 1'b0;
                  cmd_valid  <= 1'b1;
               end
            end
         end
      end
   end

   // R8
   foreign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !collecting && !is_known(rx_data)) |=> (!cmd_valid && !collecting));

   // R9
   single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/dbgr_port_seq.sv
module dbgr_port_seq
   import dbgr_pkg::*;
#(
   parameter int TO_W  = 16,
   parameter int WDW   = WD_W,
   parameter int RDW   = RD_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  dp_op_e          op,
   input  logic [WDW-1:0]  wdata,
   input  logic [TO_W-1:0] to_limit,
   input  logic            dp_ack,
   input  logic [RDW-1:0]  dp_rdata,
   output logic            dp_req,
   output dp_op_e          dp_op,
   output logic [WDW-1:0]  dp_wdata,
   output logic            done,
   output logic            ok,
   output logic [RDW-1:0]  rdata
);

   generate
      if (TO_W < 1 || TO_W > 32) begin : g_bad_to
         $error("dbgr_port_seq: TO_W out of range");
      end
   endgenerate

   logic [TO_W-1:0] wait_cnt;
   logic [TO_W-1:0] lim_eff;
   logic            window_end;

   assign lim_eff    = (to_limit == '0) ? TO_W'(1) : to_limit;
   assign window_end = ({1'b0, wait_cnt} + 1'b1) >= {1'b0, lim_eff};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_req   <= 1'b0;
         dp_op    <= DP_RDREG;
         dp_wdata <= '0;
         wait_cnt <= '0;
         done     <= 1'b0;
         ok       <= 1'b0;
         rdata    <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            dp_req   <= 1'b1;
            dp_op    <= op;
            dp_wdata <= wdata;
            wait_cnt <= '0;
         end else if (dp_req) begin
            if (dp_ack) begin
               dp_req <= 1'b0;
               done   <= 1'b1;
               ok     <= 1'b1;
               rdata  <= dp_rdata;
            end else if (window_end) begin
               dp_req <= 1'b0;
               done   <= 1'b1;
               ok     <= 1'b0;
            end else begin
               wait_cnt <= wait_cnt + 1'b1;
            end
         end
      end
   end

   // R10
   wait_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_req |-> (wait_cnt < lim_eff));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && $past(dp_req)) |-> ($stable(dp_op) && $stable(dp_wdata)));

endmodule

// File: rtl/dbgr_reply_tx.sv
module dbgr_reply_tx
   import dbgr_pkg::*;
#(
   parameter int MAXB = RPL_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [2:0]           load_n,
   input  logic [8*MAXB-1:0]    load_bytes,
   input  logic                 tx_ready,
   output logic                 tx_valid,
   output logic [7:0]           tx_data,
   output logic                 busy
);

   generate
      if (MAXB < 2 || MAXB > 7) begin : g_bad_len
         $error("dbgr_reply_tx: MAXB must fit the 3-bit length");
      end
   endgenerate

   logic [8*MAXB-1:0] shreg;
   logic [2:0]        left;

   assign tx_valid = (left != 3'd0);
   assign tx_data  = shreg[8*MAXB-1 -: 8];
   assign busy     = tx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= 3'd0;
      end else if (load) begin
         shreg <= load_bytes;
         left  <= load_n;
      end else if (tx_valid && tx_ready) begin
         shreg <= {shreg[8*MAXB-9:0], 8'h00};
         left  <= left - 3'd1;
      end
   end

   // R11
   hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   // R9
   load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

endmodule

// File: rtl/dbg_cmd_responder.sv
module dbg_cmd_responder
   import dbgr_pkg::*;
#(
   parameter int         TO_W       = 16,
   parameter logic [7:0] CODE_LEVEL = 8'h01
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      rx_data,
   input  logic            rx_valid,
   output logic            rx_ready,
   output logic [7:0]      tx_data,
   output logic            tx_valid,
   input  logic            tx_ready,
   input  logic [TO_W-1:0] to_limit,
   output logic            dp_req,
   output logic [2:0]      dp_op,
   output logic [31:0]     dp_wdata,
   input  logic [23:0]     dp_rdata,
   input  logic            dp_ack,
   output logic            rst_ctrl_o,
   output logic            rst_tgt_o
);

   logic                    cmd_valid;
   logic [7:0]              cmd_opc;
   logic [8*ARG_BYTES-1:0]  cmd_args;
   logic                    busy;
   logic                    waiting;
   logic [7:0]              pend_opc;

   logic                    sq_start;
   dp_op_e                  sq_op;
   logic [WD_W-1:0]         sq_wdata;
   dp_op_e                  sq_dp_op;
   logic                    sq_done;
   logic                    sq_ok;
   logic [RD_W-1:0]         sq_rdata;

   logic                    rp_load;
   logic [2:0]              rp_n;
   logic [8*RPL_BYTES-1:0]  rp_bytes;
   logic                    rp_busy;

   assign rx_ready = 1'b1;
   assign busy     = cmd_valid || waiting || rp_busy;
   assign dp_op    = sq_dp_op;

   dbgr_cmd_parse #(.ARG_MAX(ARG_BYTES)) i_parse (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .busy(busy), .cmd_valid(cmd_valid), .cmd_opc(cmd_opc), .cmd_args(cmd_args)
   );

   dbgr_port_seq #(.TO_W(TO_W), .WDW(WD_W), .RDW(RD_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(sq_start), .op(sq_op), .wdata(sq_wdata),
      .to_limit(to_limit), .dp_ack(dp_ack), .dp_rdata(dp_rdata),
      .dp_req(dp_req), .dp_op(sq_dp_op), .dp_wdata(dp_wdata),
      .done(sq_done), .ok(sq_ok), .rdata(sq_rdata)
   );

   dbgr_reply_tx #(.MAXB(RPL_BYTES)) i_reply (
      .clk(clk), .rst_n(rst_n), .load(rp_load), .load_n(rp_n),
      .load_bytes(rp_bytes), .tx_ready(tx_ready), .tx_valid(tx_valid),
      .tx_data(tx_data), .busy(rp_busy)
   );

   // dispatch of new commands and of finished debug-port requests
   always_comb begin
      sq_start = 1'b0;
      sq_op    = DP_RDREG;
      sq_wdata = '0;
      rp_load  = 1'b0;
      rp_n     = 3'd0;
      rp_bytes = '0;
      if (cmd_valid) begin
         case (cmd_opc)
            OPC_RDREG: begin sq_start = 1'b1; sq_op = DP_RDREG; sq_wdata = {24'h0, cmd_args[7:0]}; end
            OPC_WR1:   begin sq_start = 1'b1; sq_op = DP_WR1;   sq_wdata = {24'h0, cmd_args[7:0]}; end
            OPC_WR4:   begin sq_start = 1'b1; sq_op = DP_WR4;   sq_wdata = cmd_args; end
            OPC_HALT:  begin sq_start = 1'b1; sq_op = DP_HALT;  end
            OPC_FREE:  begin sq_start = 1'b1; sq_op = DP_FREE;  end
            OPC_STAT:  begin sq_start = 1'b1; sq_op = DP_STAT;  end
            OPC_PING:  begin rp_load = 1'b1; rp_n = 3'd1; rp_bytes = {RPL_ALIVE, 24'h0}; end
            OPC_LEVEL: begin rp_load = 1'b1; rp_n = 3'd1; rp_bytes = {CODE_LEVEL, 24'h0}; end
            default: ;
         endcase
      end else if (sq_done) begin
         rp_load = 1'b1;
         rp_n    = 3'd1;
         case (pend_opc)
            OPC_RDREG: if (sq_ok) begin rp_n = 3'd4; rp_bytes = {RPL_DATA, sq_rdata}; end
                       else rp_bytes = {RPL_FAIL, 24'h0};
            OPC_STAT:  if (sq_ok) begin rp_n = 3'd2; rp_bytes = {RPL_DATA, sq_rdata[7:0], 16'h0}; end
                       else rp_bytes = {RPL_FAIL, 24'h0};
            OPC_HALT:  rp_bytes = {(sq_ok ? RPL_HALTED : RPL_DEAD), 24'h0};
            OPC_FREE:  rp_bytes = {RPL_FREED, 24'h0};
            default:   rp_bytes = {(sq_ok ? RPL_WR_OK : RPL_FAIL), 24'h0};
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting    <= 1'b0;
         pend_opc   <= '0;
         rst_ctrl_o <= 1'b0;
         rst_tgt_o  <= 1'b0;
      end else begin
         if (sq_start) begin
            waiting  <= 1'b1;
            pend_opc <= cmd_opc;
         end else if (sq_done) begin
            waiting <= 1'b0;
         end
         rst_ctrl_o <= cmd_valid && (cmd_opc == OPC_RSTALL || cmd_opc == OPC_RSTCTL);
         rst_tgt_o  <= cmd_valid && (cmd_opc == OPC_RSTALL || cmd_opc == OPC_RSTTGT);
      end
   end

   // R6
   tgt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_tgt_o |=> !rst_tgt_o);

   // R6
   ctrl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ctrl_o |=> !rst_ctrl_o);

   // R9
   no_reply_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_req |-> !tx_valid);

endmodule

// File: tb/test_dbg_cmd_responder.sv
`timescale 1ns/1ps
module test_dbg_cmd_responder;

   localparam int TO_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      rx_data = 8'h00;
   logic            rx_valid = 1'b0;
   logic            rx_ready;
   logic [7:0]      tx_data;
   logic            tx_valid;
   logic            tx_ready = 1'b0;
   logic [TO_W-1:0] to_limit = 16'd6;
   logic            dp_req;
   logic [2:0]      dp_op;
   logic [31:0]     dp_wdata;
   logic [23:0]     dp_rdata = 24'h0;
   logic            dp_ack = 1'b0;
   logic            rst_ctrl_o;
   logic            rst_tgt_o;

   always #2 clk = ~clk;

   dbg_cmd_responder #(.TO_W(TO_W), .CODE_LEVEL(8'h01)) i_dbg_cmd_responder (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .to_limit(to_limit), .dp_req(dp_req), .dp_op(dp_op),
      .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_ack(dp_ack),
      .rst_ctrl_o(rst_ctrl_o), .rst_tgt_o(rst_tgt_o)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // bench-side target and sink state
   bit         tgt_alive = 1;
   int         tgt_delay = 0;
   logic [23:0] tgt_rd = 24'h0;
   int         rdy_mode = 0;
   logic [7:0] got [0:15];
   int         got_n = 0;
   int         req_count = 0;
   int         req_cycles = 0;
   logic [2:0] seen_op = 3'd0;
   logic [31:0] seen_wdata = 32'h0;
   int         pulses_c = 0;
   int         pulses_t = 0;
   bit         in_req = 0;
   int         wcnt = 0;

   always @(negedge clk) begin
      if (dp_req) begin
         if (!in_req) begin
            in_req = 1;
            req_count++;
            seen_op = dp_op;
            seen_wdata = dp_wdata;
            wcnt = 0;
         end else begin
            wcnt++;
         end
         req_cycles++;
         dp_ack   = tgt_alive && (wcnt == tgt_delay);
         dp_rdata = tgt_rd;
      end else begin
         in_req = 0;
         dp_ack = 1'b0;
      end
      if (rst_ctrl_o) pulses_c++;
      if (rst_tgt_o) pulses_t++;
   end

   always @(negedge clk) begin
      bit r;
      if (rdy_mode == 1) r = 1;
      else if (rdy_mode == 2) r = 0;
      else r = ($urandom_range(0, 3) != 0);
      if (tx_valid && r && got_n < 16) begin
         got[got_n] = tx_data;
         got_n++;
      end
      tx_ready = r;
   end

   task automatic chk(input bit cond, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_data  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic clear_obs();
      got_n = 0; req_count = 0; req_cycles = 0; pulses_c = 0; pulses_t = 0;
   endtask

   function automatic int nargs_of(input logic [7:0] o);
      if (o == 8'hA0 || o == 8'hA1) return 1;
      if (o == 8'hA2) return 4;
      return 0;
   endfunction

   function automatic bit is_dp(input logic [7:0] o);
      return (o == 8'hA0 || o == 8'hA1 || o == 8'hA2 || o == 8'hA5 ||
              o == 8'hA6 || o == 8'hA7);
   endfunction

   function automatic logic [2:0] op_of(input logic [7:0] o);
      case (o)
         8'hA0: return 3'd0; 8'hA1: return 3'd1; 8'hA2: return 3'd2;
         8'hA5: return 3'd3; 8'hA6: return 3'd4; default: return 3'd5;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] o);
      case (o)
         8'hA0: return "R2"; 8'hA1, 8'hA2: return "R3";
         8'hA5, 8'hA6: return "R4"; 8'hA7: return "R5";
         8'hA3, 8'hA4, 8'hA9: return "R6"; 8'hAC, 8'hAD: return "R7";
         default: return "R8";
      endcase
   endfunction

   // full command with checks; all reply expectations built from requirements
   task automatic run_cmd(input logic [7:0] opc, input logic [31:0] args,
                          input bit alive, input int delay);
      logic [7:0] e [0:3];
      int en;
      int lim;
      bit ok;
      string tg;
      tg = tag_of(opc);
      tgt_alive = alive;
      tgt_delay = delay;
      tgt_rd = 24'($urandom);
      clear_obs();
      send_byte(opc);
      if (nargs_of(opc) == 1) send_byte(args[7:0]);
      if (nargs_of(opc) == 4) begin
         send_byte(args[31:24]); send_byte(args[23:16]);
         send_byte(args[15:8]);  send_byte(args[7:0]);
      end
      repeat (80) @(negedge clk);
      lim = (to_limit == 0) ? 1 : int'(to_limit);
      ok = alive && (delay + 1 <= lim);
      en = 0;
      case (opc)
         8'hA0: if (ok) begin e[0]=8'hD7; e[1]=tgt_rd[23:16]; e[2]=tgt_rd[15:8]; e[3]=tgt_rd[7:0]; en=4; end
                else begin e[0]=8'hD2; en=1; end
         8'hA1, 8'hA2: begin e[0] = ok ? 8'hD1 : 8'hD2; en = 1; end
         8'hA5: begin e[0] = ok ? 8'hD5 : 8'hD3; en = 1; end
         8'hA6: begin e[0] = 8'hD4; en = 1; end
         8'hA7: if (ok) begin e[0]=8'hD7; e[1]=tgt_rd[7:0]; en=2; end
                else begin e[0]=8'hD2; en=1; end
         8'hAC: begin e[0] = 8'hD6; en = 1; end
         8'hAD: begin e[0] = 8'h01; en = 1; end
         default: en = 0;
      endcase
      chk(got_n == en, tg, $sformatf("reply count op %0h", opc), got_n, en);
      for (int i = 0; i < en && i < got_n; i++)
         chk(got[i] == e[i], tg, $sformatf("reply byte %0d op %0h", i, opc), got[i], e[i]);
      if (is_dp(opc)) begin
         chk(req_count == 1, tg, "request count", req_count, 1);
         chk(seen_op == op_of(opc), tg, "dp_op", seen_op, op_of(opc));
         if (opc == 8'hA2)
            chk(seen_wdata == args, "R3", "dp_wdata four bytes", seen_wdata, args);
         else if (opc == 8'hA0 || opc == 8'hA1)
            chk(seen_wdata == {24'h0, args[7:0]}, tg, "dp_wdata one byte", seen_wdata, {24'h0, args[7:0]});
      end else begin
         chk(req_count == 0, tg, "no request", req_count, 0);
      end
      chk(pulses_c == ((opc == 8'hA3 || opc == 8'hA9) ? 1 : 0), tg, "ctrl pulses",
          pulses_c, (opc == 8'hA3 || opc == 8'hA9) ? 1 : 0);
      chk(pulses_t == ((opc == 8'hA3 || opc == 8'hA4) ? 1 : 0), tg, "tgt pulses",
          pulses_t, (opc == 8'hA3 || opc == 8'hA4) ? 1 : 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] pool [0:15];
      void'($urandom(32'h5EED_0D5A));
      pool = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
               8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAC, 8'hAD, 8'h3C, 8'hFF};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tx_valid == 0, "R1", "tx_valid in reset", tx_valid, 0);
      chk(dp_req == 0, "R1", "dp_req in reset", dp_req, 0);
      chk(rst_ctrl_o == 0 && rst_tgt_o == 0, "R1", "reset pulses in reset",
          {rst_ctrl_o, rst_tgt_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(rx_ready == 1, "R1", "rx_ready after reset", rx_ready, 1);
      chk(tx_valid == 0 && dp_req == 0, "R1", "idle after reset", {tx_valid, dp_req}, 0);

      // directed: every opcode, live and silent target
      to_limit = 16'd6;
      run_cmd(8'hAC, 0, 1, 0);            // R7
      run_cmd(8'hAD, 0, 1, 0);            // R7
      run_cmd(8'hA0, 32'h5A, 1, 2);       // R2
      run_cmd(8'hA0, 32'h33, 0, 0);       // R5 read timeout
      run_cmd(8'hA1, 32'hC4, 1, 0);       // R3
      run_cmd(8'hA1, 32'h81, 0, 0);       // R3 failure
      run_cmd(8'hA2, 32'h1234_ABCD, 1, 5);// R3 byte order
      run_cmd(8'hA2, 32'hFFEE_0001, 0, 0);// R3 failure
      run_cmd(8'hA5, 0, 1, 1);            // R4
      run_cmd(8'hA5, 0, 0, 0);            // R4 dead target
      run_cmd(8'hA6, 0, 0, 0);            // R4 release always D4
      run_cmd(8'hA7, 0, 1, 0);            // R5
      run_cmd(8'hA7, 0, 0, 0);            // R5 timeout
      run_cmd(8'hA3, 0, 1, 0);            // R6
      run_cmd(8'hA4, 0, 1, 0);            // R6
      run_cmd(8'hA9, 0, 1, 0);            // R6
      run_cmd(8'hA8, 0, 1, 0);            // R8
      run_cmd(8'hAA, 0, 1, 0);            // R8
      run_cmd(8'hAB, 0, 1, 0);            // R8
      run_cmd(8'h55, 0, 1, 0);            // R8
      run_cmd(8'hAC, 0, 1, 0);            // R8 decoding resumes

      // R10 timeout window edges
      to_limit = 16'd4;
      run_cmd(8'hA5, 0, 0, 0);
      chk(req_cycles == 4, "R10", "request length dead, limit 4", req_cycles, 4);
      run_cmd(8'hA5, 0, 1, 3);
      chk(req_cycles == 4, "R10", "ack in last window cycle", req_cycles, 4);
      run_cmd(8'hA5, 0, 1, 4);
      chk(req_cycles == 4, "R10", "ack one cycle late", req_cycles, 4);
      to_limit = 16'd0;
      run_cmd(8'hA1, 32'h07, 0, 0);
      chk(req_cycles == 1, "R10", "zero limit acts as one", req_cycles, 1);
      run_cmd(8'hA1, 32'h07, 1, 0);
      to_limit = 16'd6;

      // R9 bytes during execution and during a stalled reply are dropped
      clear_obs();
      tgt_alive = 1; tgt_delay = 4; tgt_rd = 24'hC0FFEE;
      send_byte(8'hA0); send_byte(8'h11);
      send_byte(8'hAC);
      rdy_mode = 2;
      repeat (20) @(negedge clk);
      send_byte(8'hAD);
      send_byte(8'hA4);
      chk(tx_valid == 1 && tx_data == 8'hD7, "R11", "stalled byte held",
          {tx_valid, tx_data}, {1'b1, 8'hD7});
      rdy_mode = 1;
      repeat (30) @(negedge clk);
      rdy_mode = 0;
      chk(got_n == 4, "R9", "only first reply sent", got_n, 4);
      chk(got[0] == 8'hD7 && got[1] == 8'hC0 && got[2] == 8'hFF && got[3] == 8'hEE,
          "R9", "first reply intact", {got[0], got[1], got[2], got[3]}, 32'hD7C0FFEE);
      chk(req_count == 1 && pulses_t == 0, "R9", "no side effect from dropped bytes",
          {req_count[15:0], pulses_t[15:0]}, 32'h0001_0000);
      run_cmd(8'hAC, 0, 1, 0);

      // constrained random command stream
      for (int n = 0; n < 150; n++) begin
         run_cmd(pool[$urandom_range(0, 15)], $urandom,
                 ($urandom_range(0, 3) != 0), $urandom_range(0, 8));
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule